// File: doc/BRIEF.md
# Escaped Byte-Stream Packet Deframer

This block takes a physical-layer byte stream and recovers the payload packets carried in it. The stream arrives either one byte per transfer or as words of several bytes, which the block splits and handles one byte per clock. A packet opens with a start marker, and a channel marker followed by a channel number of zero comes before the payload. Marker-valued payload bytes are sent as an escape code followed by the byte XOR 0x20. The end marker does not close the packet on its own. The packet closes on the first data byte that follows the end marker, and that byte is the final payload byte.

Recovered payload bytes leave on a valid/last/data interface, one byte per clock. Whenever a partial packet is discarded, the block raises a one-cycle abort pulse with a cause code. The causes are protocol faults, payload overflow and a restart by a new start marker. A downstream consumer drops whatever it has gathered since the last completed packet when it sees the abort pulse. Idle fill bytes are ignored throughout.

Top module: `escaped_stream_deframer`

## Requirements
- R1: Before a start marker 0x7A is seen, every byte is ignored, including end, channel, escape and data values, and produces no output.
- R2: The idle byte 0x4A is ignored at every point, including between a channel marker and its number and between an escape code and the escaped byte.
- R3: The first non-idle byte after a channel marker 0x7C must be 0x00 and is not output. Any other value aborts the packet with cause 1.
- R4: Either 0x7D or 0x4D acts as an escape code. The next data byte is output XOR 0x20.
- R5: An escape code followed by another escape code, an end marker 0x7B or a channel marker aborts the packet with cause 2.
- R6: An end marker or a channel marker seen after the end marker of the same packet aborts the packet with cause 3.
- R7: The first data byte after the end marker is output with out_last high, and the block then hunts for a new start marker.
- R8: A start marker inside a packet gives an abort with cause 5 and starts a fresh packet at once.
- R9: A packet may carry at most MAX_PAYLOAD (default 1024) payload bytes. A further payload byte is not output, and it aborts the packet with cause 4.
- R10: With LANES bytes per input word, the byte in bits [8*LANES-1:8*LANES-8] is handled first. in_ready is low until the last byte of the held word is being consumed.
- R11: out_abort is a one-cycle pulse that never coincides with out_valid. After any abort other than cause 5, the block hunts for a start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 8*LANES | Input word, first byte in the top lane |
| out_valid | output | 1 | Payload byte present |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final byte of the packet |
| out_abort | output | 1 | Partial packet discarded |
| out_cause | output | 3 | Abort cause: 1 channel, 2 escape, 3 end sequence, 4 overflow, 5 restart |

## Verification
The hardest case to reach is the overflow boundary. It needs more than a thousand payload bytes with no stray marker, so random traffic never gets there. Directed frames of exactly MAX_PAYLOAD bytes and of one byte more reach it, each closed by the end marker. The fault sequences sit inside escape or post-end windows only a byte wide, and idle bytes are interleaved there on purpose. Every stream goes through both a word-wide and a byte-wide instance and is compared against a bench model, so lane order and in_ready pacing are covered on the same data.

// File: rtl/esc_deframe_pkg.sv
// Shared constants and types for the escaped byte-stream deframer.
// Assumes byte-wide symbols; marker values are fixed by the line protocol.
package esc_deframe_pkg;

    localparam logic [7:0] MK_START  = 8'h7A;
    localparam logic [7:0] MK_END    = 8'h7B;
    localparam logic [7:0] MK_CHAN   = 8'h7C;
    localparam logic [7:0] MK_ESC_A  = 8'h7D;
    localparam logic [7:0] MK_ESC_B  = 8'h4D;
    localparam logic [7:0] MK_IDLE   = 8'h4A;
    localparam logic [7:0] ESC_FLIP  = 8'h20;
    localparam logic [7:0] CHAN_ZERO = 8'h00;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_CHANNEL  = 3'd1,
        CAUSE_ESCAPE   = 3'd2,
        CAUSE_END      = 3'd3,
        CAUSE_OVERFLOW = 3'd4,
        CAUSE_RESTART  = 3'd5
    } abort_cause_t;

    typedef enum logic [2:0] {
        K_DATA,
        K_START,
        K_END,
        K_CHAN,
        K_ESC,
        K_IDLE
    } byte_kind_t;

    // Map a raw line byte to its protocol role.
    function automatic byte_kind_t classify(input logic [7:0] b);
        byte_kind_t k;
        unique case (b)
            MK_START:           k = K_START;
            MK_END:             k = K_END;
            MK_CHAN:            k = K_CHAN;
            MK_ESC_A, MK_ESC_B: k = K_ESC;
            MK_IDLE:            k = K_IDLE;
            default:            k = K_DATA;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/lane_splitter.sv
// Splits LANES-byte input words into a one-byte-per-clock stream.
// The top lane goes out first. Assumes the consumer takes every byte
// (no backpressure downstream); in_ready throttles the word source.
module lane_splitter #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [8*LANES-1:0] in_data,
    output logic               byte_valid,
    output logic [7:0]         byte_data
);

    localparam int WORD_W = 8 * LANES;
    localparam int LEFT_W = $clog2(LANES + 1);

    generate
        if (LANES == 1) begin : g_byte
            logic       bv_q;
            logic [7:0] bd_q;

            assign in_ready = 1'b1;

            // Register one byte per accepted transfer.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bv_q <= 1'b0;
                    bd_q <= '0;
                end else begin
                    bv_q <= in_valid;
                    bd_q <= in_data[7:0];
                end
            end

            assign byte_valid = bv_q;
            assign byte_data  = bd_q;
        end else begin : g_word
            logic [WORD_W-1:0] hold_q;
            logic [LEFT_W-1:0] left_q;

            assign in_ready = (left_q <= LEFT_W'(1));

            // Load a word when the previous one is on its last byte, else shift.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_q <= '0;
                    left_q <= '0;
                end else if (in_valid && in_ready) begin
                    hold_q <= in_data;
                    left_q <= LEFT_W'(LANES);
                end else if (left_q != '0) begin
                    hold_q <= hold_q << 8;
                    left_q <= left_q - LEFT_W'(1);
                end
            end

            assign byte_valid = (left_q != '0);
            assign byte_data  = hold_q[WORD_W-1 -: 8];

            // A held word with more than one byte left blocks new words.
            p_ready_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (left_q > LEFT_W'(1)) |-> !in_ready);
        end
    endgenerate

    // An accepted word always yields a byte on the next cycle.
    p_take_yields_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> byte_valid);

endmodule

// File: rtl/frame_byte_decoder.sv
// Decodes one line byte per clock into payload bytes and abort events.
// Tracks hunt/in-packet state, pending channel number, pending escape,
// seen-end flag and the payload count. Outputs are registered, one clock
// after the input byte. Assumes the input byte is valid for one clock only.
module frame_byte_decoder
    import esc_deframe_pkg::*;
#(
    parameter int MAX_PAYLOAD = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         byte_valid,
    input  logic [7:0]   byte_data,
    output logic         out_valid,
    output logic [7:0]   out_data,
    output logic         out_last,
    output logic         out_abort,
    output abort_cause_t out_cause
);

    localparam int CNT_W = $clog2(MAX_PAYLOAD + 1);

    byte_kind_t   kind;
    logic         in_pkt_q, esc_q, end_q, chan_q;
    logic [CNT_W-1:0] cnt_q;

    logic         n_in, n_esc, n_end, n_chan;
    logic [CNT_W-1:0] n_cnt;
    logic         emit, emit_last;
    logic [7:0]   emit_data;
    abort_cause_t cause;

    assign kind = classify(byte_data);

    // Next-state and event decision for the current byte.
    always_comb begin
        n_in      = in_pkt_q;
        n_esc     = esc_q;
        n_end     = end_q;
        n_chan    = chan_q;
        n_cnt     = cnt_q;
        emit      = 1'b0;
        emit_last = 1'b0;
        emit_data = esc_q ? (byte_data ^ ESC_FLIP) : byte_data;
        cause     = CAUSE_NONE;
        if (byte_valid) begin
            if (!in_pkt_q) begin
                if (kind == K_START) begin
                    n_in = 1'b1;
                    n_esc = 1'b0;
                    n_end = 1'b0;
                    n_chan = 1'b0;
                    n_cnt = '0;
                end
            end else if (kind == K_IDLE) begin
                n_in = in_pkt_q;
            end else if (chan_q) begin
                if (byte_data != CHAN_ZERO) cause = CAUSE_CHANNEL;
                else                        n_chan = 1'b0;
            end else begin
                unique case (kind)
                    K_START: cause = CAUSE_RESTART;
                    K_END: begin
                        if (esc_q)      cause = CAUSE_ESCAPE;
                        else if (end_q) cause = CAUSE_END;
                        else            n_end = 1'b1;
                    end
                    K_CHAN: begin
                        if (esc_q)      cause = CAUSE_ESCAPE;
                        else if (end_q) cause = CAUSE_END;
                        else            n_chan = 1'b1;
                    end
                    K_ESC: begin
                        if (esc_q) cause = CAUSE_ESCAPE;
                        else       n_esc = 1'b1;
                    end
                    K_DATA: begin
                        if (cnt_q == CNT_W'(MAX_PAYLOAD)) begin
                            cause = CAUSE_OVERFLOW;
                        end else begin
                            emit      = 1'b1;
                            emit_last = end_q;
                            n_esc     = 1'b0;
                            n_cnt     = cnt_q + CNT_W'(1);
                            if (end_q) begin
                                n_in  = 1'b0;
                                n_end = 1'b0;
                                n_cnt = '0;
                            end
                        end
                    end
                    default: n_in = in_pkt_q;
                endcase
            end
            if (cause == CAUSE_RESTART) begin
                n_in   = 1'b1;
                n_esc  = 1'b0;
                n_end  = 1'b0;
                n_chan = 1'b0;
                n_cnt  = '0;
            end else if (cause != CAUSE_NONE) begin
                n_in   = 1'b0;
                n_esc  = 1'b0;
                n_end  = 1'b0;
                n_chan = 1'b0;
                n_cnt  = '0;
            end
        end
    end

    // Protocol state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt_q <= 1'b0;
            esc_q    <= 1'b0;
            end_q    <= 1'b0;
            chan_q   <= 1'b0;
            cnt_q    <= '0;
        end else begin
            in_pkt_q <= n_in;
            esc_q    <= n_esc;
            end_q    <= n_end;
            chan_q   <= n_chan;
            cnt_q    <= n_cnt;
        end
    end

    // Output event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
            out_abort <= 1'b0;
            out_cause <= CAUSE_NONE;
        end else begin
            out_valid <= emit;
            out_last  <= emit && emit_last;
            if (emit) out_data <= emit_data;
            out_abort <= (cause != CAUSE_NONE);
            out_cause <= cause;
        end
    end

    // Idle bytes never produce output, whatever the state.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && kind == K_IDLE) |=> (!out_valid && !out_abort));

    // No input byte, no output event.
    p_no_byte_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> (!out_valid && !out_abort));

    // Payload and abort never share a cycle.
    p_excl_events_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_abort}));

    // A last flag only rides on a payload byte, and closes the packet.
    p_last_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && !in_pkt_q));

    // Fault aborts return to hunting; a restart stays in a packet.
    p_abort_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_abort |-> (in_pkt_q == (out_cause == CAUSE_RESTART)));

    // Payload count never passes the limit.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_PAYLOAD));

endmodule

// File: rtl/escaped_stream_deframer.sv
// Top of the escaped byte-stream deframer: word splitter feeding the
// byte decoder. Assumes the output consumer accepts one event per clock.
module escaped_stream_deframer
    import esc_deframe_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int MAX_PAYLOAD = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [8*LANES-1:0] in_data,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic               out_last,
    output logic               out_abort,
    output logic [2:0]         out_cause
);

    logic         bv;
    logic [7:0]   bd;
    abort_cause_t cause_e;

    lane_splitter #(.LANES(LANES)) u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .byte_valid (bv),
        .byte_data  (bd)
    );

    frame_byte_decoder #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (bv),
        .byte_data  (bd),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_abort  (out_abort),
        .out_cause  (cause_e)
    );

    assign out_cause = cause_e;

endmodule

// File: tb/test_escaped_stream_deframer.sv
module test_escaped_stream_deframer;

    typedef logic [7:0] bq_t[$];
    typedef int eq_t[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // word-wide instance
    logic        w_valid = 1'b0, w_ready;
    logic [31:0] w_data = '0;
    logic        w_ov, w_ol, w_oa;
    logic [7:0]  w_od;
    logic [2:0]  w_oc;
    // byte-wide instance
    logic        b_valid = 1'b0, b_ready;
    logic [7:0]  b_data = '0;
    logic        b_ov, b_ol, b_oa;
    logic [7:0]  b_od;
    logic [2:0]  b_oc;

    int checks = 0, errors = 0;
    bit done = 0;
    eq_t got_w, got_b;

    escaped_stream_deframer i_escaped_stream_deframer (
        .clk(clk), .rst_n(rst_n), .in_valid(w_valid), .in_ready(w_ready),
        .in_data(w_data), .out_valid(w_ov), .out_data(w_od), .out_last(w_ol),
        .out_abort(w_oa), .out_cause(w_oc));

    escaped_stream_deframer #(.LANES(1)) i_escaped_stream_deframer_b (
        .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_ready(b_ready),
        .in_data(b_data), .out_valid(b_ov), .out_data(b_od), .out_last(b_ol),
        .out_abort(b_oa), .out_cause(b_oc));

    // Event log: 0x0XX data, 0x1XX data+last, 0x20C abort with cause C.
    always @(negedge clk) begin
        if (rst_n) begin
            if (w_ov) got_w.push_back((w_ol ? 32'h100 : 32'h0) | int'(w_od));
            if (w_oa) got_w.push_back(32'h200 | int'(w_oc));
            if (b_ov) got_b.push_back((b_ol ? 32'h100 : 32'h0) | int'(b_od));
            if (b_oa) got_b.push_back(32'h200 | int'(b_oc));
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Requirement model of the deframer.
    function automatic eq_t model(input bq_t s);
        eq_t e;
        bit in = 0, esc = 0, en = 0, ch = 0;
        int cnt = 0, ab;
        foreach (s[i]) begin
            logic [7:0] b = s[i];
            ab = 0;
            if (!in) begin
                if (b == 8'h7A) begin in = 1; esc = 0; en = 0; ch = 0; cnt = 0; end
                continue;
            end
            if (b == 8'h4A) continue;
            if (ch) begin
                if (b != 8'h00) ab = 1; else ch = 0;
            end else if (b == 8'h7A) ab = 5;
            else if (b == 8'h7B) begin
                if (esc) ab = 2; else if (en) ab = 3; else en = 1;
            end else if (b == 8'h7C) begin
                if (esc) ab = 2; else if (en) ab = 3; else ch = 1;
            end else if (b == 8'h7D || b == 8'h4D) begin
                if (esc) ab = 2; else esc = 1;
            end else begin
                if (cnt == 1024) ab = 4;
                else begin
                    e.push_back((en ? 32'h100 : 32'h0) | int'(esc ? (b ^ 8'h20) : b));
                    esc = 0; cnt++;
                    if (en) begin in = 0; en = 0; end
                end
            end
            if (ab != 0) begin
                e.push_back(32'h200 | ab);
                esc = 0; en = 0; ch = 0; cnt = 0;
                in = (ab == 5);
            end
        end
        return e;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; w_valid = 1'b0; b_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic feed_word(input bq_t s);
        bq_t p = s;
        while (p.size() % 4 != 0) p.push_back(8'h4A);
        for (int i = 0; i < p.size(); i += 4) begin
            w_valid = 1'b1;
            w_data = {p[i], p[i+1], p[i+2], p[i+3]};
            while (!w_ready) @(negedge clk);
            @(negedge clk);
        end
        w_valid = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic feed_byte(input bq_t s);
        foreach (s[i]) begin
            b_valid = 1'b1; b_data = s[i];
            @(negedge clk);
        end
        b_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run(input string req, input bq_t s);
        eq_t e = model(s);
        do_reset();
        got_w.delete(); got_b.delete();
        feed_word(s);
        feed_byte(s);
        check({"R10/", req, " word count"}, got_w.size(), e.size());
        check({req, " byte count"}, got_b.size(), e.size());
        foreach (e[i]) begin
            check({"R10/", req, " word event"}, (i < got_w.size()) ? got_w[i] : -1, e[i]);
            check({req, " byte event"}, (i < got_b.size()) ? got_b[i] : -1, e[i]);
        end
    endtask

    function automatic logic [7:0] rnd_byte();
        return 8'($urandom);
    endfunction

    function automatic bit is_marker(input logic [7:0] b);
        return b == 8'h7A || b == 8'h7B || b == 8'h7C || b == 8'h7D ||
               b == 8'h4A || b == 8'h4D;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bq_t s;
        void'($urandom(32'd20240611));
        do_reset();
        // R11 reset state, R10 ready after reset
        check("R11 reset out_valid", int'(w_ov), 0);
        check("R11 reset out_abort", int'(w_oa), 0);
        check("R10 reset in_ready", int'(w_ready), 1);
        // R10 in_ready pacing across one word
        w_valid = 1'b1; w_data = 32'h7A7C0011;
        @(negedge clk); w_valid = 1'b0;
        check("R10 ready lane4", int'(w_ready), 0);
        @(negedge clk); check("R10 ready lane3", int'(w_ready), 0);
        @(negedge clk); check("R10 ready lane2", int'(w_ready), 0);
        @(negedge clk); check("R10 ready lane1", int'(w_ready), 1);

        // R1 junk before start marker
        s = '{8'h11, 8'h7B, 8'h7C, 8'h7D, 8'h00, 8'h33};
        run("R1 junk only", s);
        s = '{8'h7B, 8'h55, 8'h7A, 8'h7C, 8'h00, 8'h41, 8'h7B, 8'h42};
        run("R1 junk then packet", s);
        // R7 plain packet
        s = '{8'h7A, 8'h7C, 8'h00, 8'h01, 8'h02, 8'h03, 8'h7B, 8'h04};
        run("R7 basic", s);
        // R2 idles everywhere
        s = '{8'h4A, 8'h7A, 8'h4A, 8'h7C, 8'h4A, 8'h00, 8'h4A, 8'h7D, 8'h4A,
              8'h5A, 8'h7B, 8'h4A, 8'h09};
        run("R2 idles", s);
        // R4 both escape codes, escaped last byte
        s = '{8'h7A, 8'h7C, 8'h00, 8'h7D, 8'h5A, 8'h4D, 8'h6A, 8'h7B, 8'h7D, 8'h5D};
        run("R4 escapes", s);
        // R3 channel errors
        s = '{8'h7A, 8'h7C, 8'h01, 8'h22, 8'h7A, 8'h7C, 8'h00, 8'h7B, 8'h23};
        run("R3 bad channel", s);
        s = '{8'h7A, 8'h7C, 8'h7A, 8'h44};
        run("R3 marker as channel", s);
        // R5 escape errors
        s = '{8'h7A, 8'h7D, 8'h4D, 8'h7A, 8'h7D, 8'h7B, 8'h7A, 8'h4D, 8'h7C};
        run("R5 escape sequences", s);
        // R6 end sequence errors
        s = '{8'h7A, 8'h10, 8'h7B, 8'h7B, 8'h7A, 8'h7B, 8'h7C, 8'h00, 8'h66};
        run("R6 end sequences", s);
        // R8 restart mid-packet
        s = '{8'h7A, 8'h7C, 8'h00, 8'h31, 8'h7A, 8'h7C, 8'h00, 8'h32, 8'h7B, 8'h33};
        run("R8 restart", s);
        // R9 exact limit passes, one more overflows
        s = '{8'h7A, 8'h7C, 8'h00};
        for (int i = 0; i < 1023; i++) s.push_back(8'h55);
        s.push_back(8'h7B); s.push_back(8'h56);
        run("R9 exact limit", s);
        s = '{8'h7A, 8'h7C, 8'h00};
        for (int i = 0; i < 1024; i++) s.push_back(8'h57);
        s.push_back(8'h58); s.push_back(8'h7B); s.push_back(8'h59);
        run("R9 overflow", s);

        // random frames, mostly well formed, with injected faults
        for (int r = 0; r < 40; r++) begin
            s.delete();
            for (int f = 0; f < 8; f++) begin
                if ($urandom % 4 == 0) s.push_back(rnd_byte());
                s.push_back(8'h7A); s.push_back(8'h7C);
                s.push_back(($urandom % 16 == 0) ? 8'h03 : 8'h00);
                for (int k = 0; k < 1 + int'($urandom % 12); k++) begin
                    logic [7:0] v = rnd_byte();
                    if ($urandom % 20 == 0) s.push_back(rnd_byte() | 8'h40);
                    if ($urandom % 6 == 0) s.push_back(8'h4A);
                    if (is_marker(v) && $urandom % 8 != 0) begin
                        s.push_back(($urandom % 2) ? 8'h7D : 8'h4D);
                        s.push_back(v ^ 8'h20);
                    end else s.push_back(v);
                end
                s.push_back(8'h7B);
                s.push_back(8'h21 + 8'($urandom % 8));
            end
            run("R7 random R4 R5 R6", s);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule